// File: doc/BRIEF.md
# Dual-Reference Failover Selector

This block decides which of two reference clocks feeds a downstream PLL. In manual mode a select pin picks the reference directly. In automatic mode the block watches the working reference and, when that reference stops toggling, moves once to the other input. After that single move it holds its choice until software drops the mode pin low and raises it again.

Each reference is judged by a monitor that runs on the free-running system clock. The monitor samples the reference through a two-flop synchronizer and counts its rising edges over a fixed window of system cycles. A window with too few edges marks the input inactive. The mode and select pins are also synchronized. Two outputs report the result: an acknowledge bit that names the selected input, and a loss flag that covers only the selected input.

Top module: `refsel_autoswitch`

## Requirements
- R1: While the mode pin `auto_en` is low, `sel_ack` follows `ref_pick` and settles within 3 system clock cycles. `sel_ack` = 0 means reference A and 1 means reference B.
- R2: When the synchronized `auto_en` goes from low to high, the `ref_pick` value at that moment becomes the working reference for automatic mode.
- R3: A successful automatic failover appears as a toggle of `sel_ack`, so the bit always names the input in use.
- R4: `ref_lost` is high exactly when the currently selected input is judged inactive. The state of the unselected input never affects it.
- R5: In armed automatic mode, on the cycle after `ref_lost` is high, `sel_ack` switches to the other input.
- R6: Only one reselection is made per arming. If the new input is also inactive, `sel_ack` still toggles once, `ref_lost` stays high, and no further switching occurs.
- R7: While `auto_en` stays high, in the armed or the switched state, `ref_pick` has no effect on `sel_ack`.
- R8: Keeping `auto_en` high after a failover never re-arms the block. Re-arming needs `auto_en` to go low and then high. Setting `ref_pick` to the current selection first keeps the working reference unchanged.
- R9: An input that shows fewer than `MIN_EDGES` rising edges in a window of `WIN_CYC` system cycles is inactive. It becomes active again after a window with at least `MIN_EDGES` edges.
- R10: Reset (synchronous, active low) puts the block in manual mode with `ref_lost` low. If `auto_en` is high when reset is released, the block arms on the value of `ref_pick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_a_clk | input | 1 | Reference clock A (must run below clk/2) |
| ref_b_clk | input | 1 | Reference clock B (must run below clk/2) |
| auto_en | input | 1 | Mode pin: 1 = automatic, 0 = manual (asynchronous) |
| ref_pick | input | 1 | Select pin: 0 = A, 1 = B (asynchronous) |
| sel_ack | output | 1 | Current selection: 0 = A, 1 = B |
| ref_lost | output | 1 | Selected reference judged inactive |

## Verification
The bench kills the unselected reference to show that a design which mixes the two activity states would raise `ref_lost` or switch for no reason. It kills both references after arming. A design that is not single-shot would then switch back and forth between the two dead inputs. It keeps `auto_en` high after a failover and toggles `ref_pick`, which would expose a design that re-arms on the level of the mode pin or that lets the select pin through. It also drives a reference that toggles too slowly and arms through a reset release with `auto_en` held high, which catches a design that counts edges wrongly or misses the arming at reset.

// File: rtl/refsw_pkg.sv
// Package: shared types and constants of the failover selector.
// Assumes: exactly two reference inputs.
package refsw_pkg;
    localparam int unsigned NUM_REFS = 2;

    typedef enum logic [1:0] {
        SW_MANUAL   = 2'd0,
        SW_ARMED    = 2'd1,
        SW_SWITCHED = 2'd2
    } sw_state_t;
endpackage

// File: rtl/refsw_sync.sv
// Module: multi-stage synchronizer for asynchronous level signals.
// Assumes: each bit is an independent level. No bus coherency is given.
module refsw_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/refsw_act_mon.sv
// Module: activity monitor for one reference clock.
// Samples the reference as data on the system clock and counts its rising
// edges in a window of WIN_CYC cycles. Reports active when the count
// reaches MIN_EDGES.
// Assumes: the reference runs below half the system clock. The monitor
// reads active until the first window closes.
module refsw_act_mon #(
    parameter int unsigned WIN_CYC   = 64,
    parameter int unsigned MIN_EDGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_clk,
    output logic active
);
    localparam int unsigned WIN_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam int unsigned CNT_W = $clog2(MIN_EDGES + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(MIN_EDGES);

    logic             ref_s;
    logic             ref_d;
    logic             rise;
    logic [WIN_W-1:0] win_cnt;
    logic [CNT_W-1:0] edge_cnt;
    logic [CNT_W-1:0] edge_nxt;
    logic             win_end;

    refsw_sync #(.WIDTH(1), .STAGES(2)) u_ref_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (ref_clk),
        .q    (ref_s)
    );

    // Delay the synchronized reference by one cycle to find rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_d <= 1'b0;
        else        ref_d <= ref_s;
    end

    assign rise    = ref_s & ~ref_d;
    assign win_end = (win_cnt == WIN_LAST);

    // Add this cycle's edge to the count, saturating at the threshold.
    always_comb begin
        edge_nxt = edge_cnt;
        if (rise && edge_cnt != CNT_SAT) edge_nxt = edge_cnt + 1'b1;
    end

    // Step the window counter and the edge count, clearing both at the window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt  <= '0;
            edge_cnt <= '0;
        end else if (win_end) begin
            win_cnt  <= '0;
            edge_cnt <= '0;
        end else begin
            win_cnt  <= win_cnt + 1'b1;
            edge_cnt <= edge_nxt;
        end
    end

    // Set the activity verdict once per window.
    always_ff @(posedge clk) begin
        if (!rst_n)       active <= 1'b1;
        else if (win_end) active <= (edge_nxt >= CNT_SAT);
    end
endmodule

// File: rtl/refsw_ctrl.sv
// Module: selection state machine.
// In manual mode the selection follows the select pin. A rising mode pin
// arms automatic mode and captures the select pin. One fault while armed
// flips the selection and locks it until the mode pin drops.
// Assumes: synchronized inputs. sel_lost is the loss state of the input
// selected now.
module refsw_ctrl
    import refsw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      auto_s,
    input  logic      pick_s,
    input  logic      sel_lost,
    output logic      sel_q,
    output sw_state_t state
);
    logic auto_d;

    // Keep the previous mode level so that only a rising edge arms the block.
    always_ff @(posedge clk) begin
        if (!rst_n) auto_d <= 1'b0;
        else        auto_d <= auto_s;
    end

    // Update the mode and the selected input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SW_MANUAL;
            sel_q <= 1'b0;
        end else if (!auto_s) begin
            state <= SW_MANUAL;
            sel_q <= pick_s;
        end else begin
            unique case (state)
                SW_MANUAL: begin
                    sel_q <= pick_s;
                    if (!auto_d) state <= SW_ARMED;
                end
                SW_ARMED: begin
                    if (sel_lost) begin
                        sel_q <= ~sel_q;
                        state <= SW_SWITCHED;
                    end
                end
                default: state <= SW_SWITCHED;
            endcase
        end
    end
endmodule

// File: rtl/refsel_autoswitch.sv
// Module: top of the dual-reference failover selector.
// Synchronizes the mode and select pins, monitors both references and
// drives the selection state machine.
// Assumes: both references run below clk/2. The pins are asynchronous.
module refsel_autoswitch
    import refsw_pkg::*;
#(
    parameter int unsigned WIN_CYC   = 64,
    parameter int unsigned MIN_EDGES = 4,
    parameter int unsigned SYNC_STG  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_a_clk,
    input  logic ref_b_clk,
    input  logic auto_en,
    input  logic ref_pick,
    output logic sel_ack,
    output logic ref_lost
);
    logic [NUM_REFS-1:0] ref_in;
    logic [NUM_REFS-1:0] ref_act;
    logic                auto_s;
    logic                pick_s;
    logic                sel_q;
    sw_state_t           state;

    assign ref_in = {ref_b_clk, ref_a_clk};

    refsw_sync #(.WIDTH(2), .STAGES(SYNC_STG)) u_pin_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({auto_en, ref_pick}),
        .q    ({auto_s, pick_s})
    );

    for (genvar g = 0; g < NUM_REFS; g++) begin : g_mon
        refsw_act_mon #(.WIN_CYC(WIN_CYC), .MIN_EDGES(MIN_EDGES)) u_mon (
            .clk    (clk),
            .rst_n  (rst_n),
            .ref_clk(ref_in[g]),
            .active (ref_act[g])
        );
    end

    refsw_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .auto_s  (auto_s),
        .pick_s  (pick_s),
        .sel_lost(ref_lost),
        .sel_q   (sel_q),
        .state   (state)
    );

    assign sel_ack  = sel_q;
    assign ref_lost = ~ref_act[sel_q];
endmodule

// File: rtl/refsel_autoswitch_chk.sv
// Module: assertion checker for refsel_autoswitch, attached with bind.
// Assumes: it sees the synchronized pins and the control state.
module refsel_autoswitch_chk
    import refsw_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      auto_s,
    input logic      pick_s,
    input sw_state_t state,
    input logic      sel_ack,
    input logic      ref_lost
);
    p_manual_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_s |=> (sel_ack == $past(pick_s)) && (state == SW_MANUAL));

    p_arm_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_s && state == SW_MANUAL) |=> (state == SW_ARMED) && (sel_ack == $past(pick_s)));

    p_failover_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_s && state == SW_ARMED && ref_lost) |=> (sel_ack != $past(sel_ack)) && (state == SW_SWITCHED));

    p_single_shot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_s && state == SW_SWITCHED) |=> $stable(sel_ack));

    p_pick_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_s && state == SW_ARMED && !ref_lost) |=> $stable(sel_ack));

    p_no_level_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_s && state == SW_SWITCHED) |=> (state == SW_SWITCHED));
endmodule

bind refsel_autoswitch refsel_autoswitch_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .auto_s  (auto_s),
    .pick_s  (pick_s),
    .state   (state),
    .sel_ack (sel_ack),
    .ref_lost(ref_lost)
);

// File: tb/refsel_autoswitch_test.sv
`timescale 1ns/1ps
module refsel_autoswitch_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_a = 1'b0;
    logic ref_b = 1'b0;
    logic auto_en = 1'b0;
    logic ref_pick = 1'b0;
    logic sel_ack;
    logic ref_lost;
    logic en_a = 1'b1;
    logic en_b = 1'b1;
    int   half_a = 10;
    int   half_b = 14;
    int   n_tests = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    logic cur;

    refsel_autoswitch uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_a_clk(ref_a),
        .ref_b_clk(ref_b),
        .auto_en  (auto_en),
        .ref_pick (ref_pick),
        .sel_ack  (sel_ack),
        .ref_lost (ref_lost)
    );

    always #2 clk = ~clk;
    always begin #(half_a); if (en_a) ref_a = ~ref_a; end
    always begin #(half_b); if (en_b) ref_b = ~ref_b; end

    // Expected selection after one automatic failover from a given input.
    function automatic logic exp_failover(input logic from_sel);
        return ~from_sel;
    endfunction

    // Expected loss flag: only the selected input's liveness counts.
    function automatic logic exp_lost(input logic sel, input logic a_ok, input logic b_ok);
        return sel ? ~b_ok : ~a_ok;
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic got, input logic exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", req, got, exp);
        end
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        // R10 reset state
        ref_pick = 1'b1;
        cyc(4);
        check("R10 lost low in reset", ref_lost, 1'b0);
        rst_n = 1'b1;
        cyc(6);
        check("R10 selection from pick", sel_ack, 1'b1);
        check("R10 lost low after reset", ref_lost, 1'b0);

        // R1 random manual selection
        for (int i = 0; i < 10; i++) begin
            ref_pick = 1'($urandom_range(0, 1));
            cyc(4);
            check("R1 manual follow", sel_ack, ref_pick);
        end

        // R2 arm with A
        ref_pick = 1'b0;
        cyc(4);
        auto_en = 1'b1;
        cyc(5);
        check("R2 arm captures pick", sel_ack, 1'b0);
        for (int i = 0; i < 6; i++) begin
            ref_pick = 1'($urandom_range(0, 1));
            cyc(5);
            check("R7 pick ignored while armed", sel_ack, 1'b0);
        end

        // R4 fault on the unselected input only
        en_b = 1'b0;
        cyc(200);
        check("R4 unselected fault not reported", ref_lost, exp_lost(1'b0, 1'b1, 1'b0));
        check("R4 no switch on unselected fault", sel_ack, 1'b0);
        en_b = 1'b1;
        cyc(200);

        // R5 / R3 fault on the selected input
        cur = sel_ack;
        en_a = 1'b0;
        cyc(200);
        check("R5 failover happened", sel_ack, exp_failover(cur));
        check("R3 ack toggled to B", sel_ack, 1'b1);
        check("R5 lost low on live B", ref_lost, 1'b0);
        for (int i = 0; i < 5; i++) begin
            ref_pick = 1'($urandom_range(0, 1));
            cyc(5);
            check("R7 pick ignored after switch", sel_ack, 1'b1);
        end
        en_a = 1'b1;
        cyc(200);

        // R8 held-high mode pin must not re-arm
        en_b = 1'b0;
        cyc(200);
        check("R8 no second switch with pin held", sel_ack, 1'b1);
        check("R4 lost high on dead selected", ref_lost, exp_lost(1'b1, 1'b1, 1'b0));
        en_b = 1'b1;
        cyc(200);
        check("R9 recovery after good window", ref_lost, 1'b0);

        // R8 re-arm keeping B, then R6 both dead
        ref_pick = 1'b1;
        cyc(4);
        auto_en = 1'b0;
        cyc(5);
        check("R8 selection kept in manual", sel_ack, 1'b1);
        auto_en = 1'b1;
        cyc(5);
        check("R8 re-armed on B", sel_ack, 1'b1);
        en_a = 1'b0;
        en_b = 1'b0;
        cyc(300);
        check("R6 single toggle to A", sel_ack, 1'b0);
        check("R6 lost stays high", ref_lost, 1'b1);
        cyc(400);
        check("R6 no further switch", sel_ack, 1'b0);

        // R9 slow reference below the edge threshold
        auto_en = 1'b0;
        ref_pick = 1'b0;
        half_a = 80;
        en_a = 1'b1;
        en_b = 1'b1;
        cyc(400);
        check("R9 slow input inactive", ref_lost, 1'b1);
        half_a = 10;
        cyc(300);
        check("R9 fast input active", ref_lost, 1'b0);

        // R10 arming on reset release with the mode pin high
        rst_n = 1'b0;
        auto_en = 1'b1;
        ref_pick = 1'b0;
        cyc(4);
        rst_n = 1'b1;
        cyc(10);
        check("R10 selection A after reset", sel_ack, 1'b0);
        en_a = 1'b0;
        cyc(200);
        check("R10 armed at reset release", sel_ack, 1'b1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule